// File: doc/BRIEF.md
# Status-Poll Controller with Millisecond Timeout

This controller sits above a byte-wide transceiver and waits for a remote device to become ready. A start request begins a loop. Each pass sends one command byte, which reads the device's control/status register, and then takes back one response byte. The loop ends with success as soon as a chosen ready bit in the response is set.

The wait is bounded by elapsed time, not by a number of attempts. A free-running millisecond tick from outside is latched, and the latched tick is consumed once after each response that is not ready. Each consumed tick lowers a down-counter. That counter is loaded with the timeout at start. When it reaches zero without a ready response, the controller ends with a timeout.

The command opcode, the register index, the ready-bit position and the timeout in milliseconds are all parameters. The command byte is the opcode OR-ed with the register index.

Top module: `stat_poll_ctrl`

## Requirements
- R1: While `tx_valid_o` is high, `tx_data_o` carries CMD_OPCODE | REG_INDEX (0x80 with the defaults). Both hold steady until a cycle with `tx_ready_i` high accepts the byte.
- R2: After a command byte is accepted, no further command is offered until a response byte arrives on `rx_valid_i`.
- R3: If bit RDY_BIT (default 1) of the response is 1, the controller finishes at once with `ok_o`=1 and `timeout_o`=0. It sends no more commands. The other response bits are ignored.
- R4: The remaining count is loaded with TIMEOUT_MS when a start is accepted. Each consumed tick lowers it by one. When the consumed tick makes it zero, the controller finishes with `timeout_o`=1 and `ok_o`=0.
- R5: A tick seen before a start, or in the same cycle as an accepted start, never shortens the new run.
- R6: A tick that arrives during a byte exchange is held. It is consumed once, after the next response that is not ready. Several ticks within one exchange count as a single tick. A tick that arrives in the same cycle as a consumption is kept for the following poll.
- R7: Responses that are not ready and arrive with no tick pending leave the count unchanged, so polling goes on indefinitely.
- R8: `done_o` is high for exactly one cycle per run, in the first cycle in which the outcome is visible. `ok_o`/`timeout_o` hold their values until the next accepted start, which clears both.
- R9: A start request while a run is in progress is ignored. It does not reload the count.
- R10: After reset the controller is idle, with `tx_valid_o`, `done_o`, `ok_o` and `timeout_o` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a polling run (accepted only when idle) |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| tx_valid_o | output | 1 | Command byte offered to transceiver |
| tx_data_o | output | 8 | Command byte |
| tx_ready_i | input | 1 | Transceiver accepts the command byte |
| rx_valid_i | input | 1 | Response byte present |
| rx_data_i | input | 8 | Response byte |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Run ended with ready bit seen |
| timeout_o | output | 1 | Run ended by exhausted timeout |

## Verification
Tick arrival and tick consumption can fall in the same cycle. The bench drives a tick in the judging cycle after a not-ready response, both with a tick already pending and without one. A bench-side model of the pending flag and the remaining count predicts in which later poll the timeout must appear. A start pulse during a response and ticks spread over the send and receive cycles are mixed in. The bench judges each case by the exact poll on which `done_o` and `timeout_o` rise.

// File: rtl/spc_pkg.sv
package spc_pkg;
   typedef enum logic [1:0] {
      SPC_IDLE  = 2'd0,
      SPC_SEND  = 2'd1,
      SPC_WAIT  = 2'd2,
      SPC_JUDGE = 2'd3
   } spc_state_e;
endpackage

// File: rtl/spc_tick_latch.sv
// Holds one pending millisecond tick until the poll loop consumes it.
module spc_tick_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   input  logic take_i,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pend_q <= 1'b0;
      else if (clear_i) pend_q <= 1'b0;   // stale ticks dropped at start
      else if (tick_i)  pend_q <= 1'b1;   // new tick survives a same-cycle take
      else if (take_i)  pend_q <= 1'b0;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/spc_ms_timer.sv
// Down-counter of remaining milliseconds; last_o flags the final unit.
module spc_ms_timer #(
   parameter int TIMEOUT_MS = 10,
   localparam int CNT_W     = $clog2(TIMEOUT_MS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic dec_i,
   output logic last_o
);
   generate
      if (TIMEOUT_MS == 1) begin : g_single
         // one tick always expires: no storage needed
         assign last_o = 1'b1;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(TIMEOUT_MS);
         localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        cnt_q <= LOAD_V;
            else if (load_i)                   cnt_q <= LOAD_V;
            else if (dec_i && cnt_q != '0)     cnt_q <= cnt_q - ONE_V;
         end

         assign last_o = (cnt_q == ONE_V);
      end
   endgenerate
endmodule

// File: rtl/spc_poll_fsm.sv
// Sequencer: send command, await response, judge, repeat.
module spc_poll_fsm
   import spc_pkg::*;
#(
   parameter int RDY_BIT = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       tx_ready_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_data_i,
   input  logic       pend_i,
   input  logic       last_i,
   output logic       accept_o,
   output logic       take_o,
   output logic       tx_valid_o,
   output logic       done_o,
   output logic       ok_o,
   output logic       timeout_o
);
   spc_state_e st_q, st_d;
   logic fin_ok, fin_to;
   logic done_q, ok_q, to_q;

   assign accept_o = (st_q == SPC_IDLE) && start_i;
   assign take_o   = (st_q == SPC_JUDGE) && pend_i;

   always_comb begin
      st_d   = st_q;
      fin_ok = 1'b0;
      fin_to = 1'b0;
      case (st_q)
         SPC_IDLE:  if (start_i) st_d = SPC_SEND;
         SPC_SEND:  if (tx_ready_i) st_d = SPC_WAIT;
         SPC_WAIT:
            if (rx_valid_i) begin
               if (rx_data_i[RDY_BIT]) begin
                  fin_ok = 1'b1;
                  st_d   = SPC_IDLE;
               end else begin
                  st_d = SPC_JUDGE;
               end
            end
         SPC_JUDGE:
            if (pend_i && last_i) begin
               fin_to = 1'b1;
               st_d   = SPC_IDLE;
            end else begin
               st_d = SPC_SEND;
            end
         default:   st_d = SPC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SPC_IDLE;
         done_q <= 1'b0;
         ok_q   <= 1'b0;
         to_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= fin_ok | fin_to;
         if (accept_o) begin
            ok_q <= 1'b0;
            to_q <= 1'b0;
         end else begin
            if (fin_ok) ok_q <= 1'b1;
            if (fin_to) to_q <= 1'b1;
         end
      end
   end

   assign tx_valid_o = (st_q == SPC_SEND);
   assign done_o     = done_q;
   assign ok_o       = ok_q;
   assign timeout_o  = to_q;
endmodule

// File: rtl/stat_poll_ctrl.sv
// Top: polls a status register until ready or the millisecond budget runs out.
module stat_poll_ctrl #(
   parameter logic [7:0] CMD_OPCODE = 8'h80,
   parameter logic [7:0] REG_INDEX  = 8'h00,
   parameter int         RDY_BIT    = 1,
   parameter int         TIMEOUT_MS = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       tick_ms_i,
   output logic       tx_valid_o,
   output logic [7:0] tx_data_o,
   input  logic       tx_ready_i,
   input  logic       rx_valid_i,
   input  logic [7:0] rx_data_i,
   output logic       done_o,
   output logic       ok_o,
   output logic       timeout_o
);
   localparam logic [7:0] CMD_BYTE = CMD_OPCODE | REG_INDEX;

   generate
      if (RDY_BIT < 0 || RDY_BIT > 7) begin : g_bad_rdy
         $error("RDY_BIT must select a bit of the response byte");
      end
      if (TIMEOUT_MS < 1) begin : g_bad_to
         $error("TIMEOUT_MS must be at least 1");
      end
   endgenerate

   logic accept, take, pend, last;

   spc_tick_latch u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .tick_i  (tick_ms_i),
      .take_i  (take),
      .pend_o  (pend)
   );

   spc_ms_timer #(.TIMEOUT_MS(TIMEOUT_MS)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .dec_i  (take),
      .last_o (last)
   );

   spc_poll_fsm #(.RDY_BIT(RDY_BIT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .tx_ready_i (tx_ready_i),
      .rx_valid_i (rx_valid_i),
      .rx_data_i  (rx_data_i),
      .pend_i     (pend),
      .last_i     (last),
      .accept_o   (accept),
      .take_o     (take),
      .tx_valid_o (tx_valid_o),
      .done_o     (done_o),
      .ok_o       (ok_o),
      .timeout_o  (timeout_o)
   );

   assign tx_data_o = CMD_BYTE;
endmodule

// File: rtl/spc_checker.sv
// Protocol properties of the poll controller, attached by bind.
module spc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       done,
   input logic       ok,
   input logic       timeout
);
   assert_cmd_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

   assert_outcome_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(ok && timeout));

   assert_ok_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ok) |-> done);

   assert_quiet_when_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tx_valid);

   assert_timeout_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout) |-> done);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_has_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ok ^ timeout));
endmodule

bind stat_poll_ctrl spc_checker u_spc_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid_o),
   .tx_ready (tx_ready_i),
   .tx_data  (tx_data_o),
   .done     (done_o),
   .ok       (ok_o),
   .timeout  (timeout_o)
);

// File: tb/tb_stat_poll_ctrl.sv
module tb_stat_poll_ctrl;
   localparam int         TO  = 3;
   localparam logic [7:0] OPC = 8'hA0;
   localparam logic [7:0] IDX = 8'h05;
   localparam logic [7:0] CMD = OPC | IDX;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, tick = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
   logic [7:0] rx_data = 8'h00;
   logic tx_valid, done, ok, tmo;
   logic [7:0] tx_data;

   int vectors = 0, errors = 0;
   int rem_m;
   bit pend_m;

   always #10 clk = ~clk;

   stat_poll_ctrl #(.CMD_OPCODE(OPC), .REG_INDEX(IDX), .RDY_BIT(1), .TIMEOUT_MS(TO)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .tick_ms_i(tick),
      .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
      .rx_valid_i(rx_valid), .rx_data_i(rx_data),
      .done_o(done), .ok_o(ok), .timeout_o(tmo));

   task automatic chk(input bit cond, input string tag, input int act, input int exp);
      vectors++;
      if (!cond) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // accept a start from idle; optionally with a coincident tick (R5)
   task automatic run_start(input bit with_tick);
      start = 1'b1; tick = with_tick;
      @(negedge clk);
      start = 1'b0; tick = 1'b0;
      rem_m = TO; pend_m = 1'b0;
      chk(ok == 1'b0 && tmo == 1'b0, "R8 start clears result", {ok, tmo}, 0);
      chk(tx_valid == 1'b1, "R1 command offered after start", tx_valid, 1);
   endtask

   // tk: 0 none, 1 send cycle, 2 response cycle, 3 judge cycle,
   //     4 send+response, 5 response+judge
   task automatic poll(input bit rdy, input int tk, input bit st);
      bit tj, fin;
      tj = (tk == 3 || tk == 5);
      chk(tx_valid == 1'b1 && tx_data == CMD, "R1 command byte", tx_data, CMD);
      tx_ready = 1'b0;
      @(negedge clk);
      chk(tx_valid == 1'b1 && tx_data == CMD, "R1 held without ready", tx_data, CMD);
      tx_ready = 1'b1; tick = (tk == 1 || tk == 4);
      @(negedge clk);
      if (tk == 1 || tk == 4) pend_m = 1'b1;
      tx_ready = 1'b0; tick = 1'b0;
      chk(tx_valid == 1'b0, "R2 no command before response", tx_valid, 0);
      rx_valid = 1'b1; rx_data = rdy ? 8'h02 : 8'hFD;
      tick = (tk == 2 || tk == 4 || tk == 5); start = st;
      @(negedge clk);
      if (tk == 2 || tk == 4 || tk == 5) pend_m = 1'b1;
      rx_valid = 1'b0; start = 1'b0; tick = tj;
      if (rdy) begin
         chk(done && ok && !tmo, "R3 ready ends run with success", {done, ok, tmo}, 3'b110);
         @(negedge clk);
         tick = 1'b0;
         chk(!done && ok && !tx_valid, "R8 done one cycle, ok held", {done, ok, tx_valid}, 3'b010);
      end else begin
         chk(!done && !tx_valid, "R2 judging after not-ready", {done, tx_valid}, 0);
         @(negedge clk);
         tick = 1'b0;
         fin = 1'b0;
         if (pend_m) begin
            rem_m--;
            fin = (rem_m == 0);
         end
         pend_m = tj;
         if (fin)
            chk(done && tmo && !ok && !tx_valid, "R4 timeout on exhausted count",
                {done, ok, tmo, tx_valid}, 4'b1010);
         else
            chk(!done && !tmo && tx_valid, "R7 R6 polling continues",
                {done, tmo, tx_valid}, 3'b001);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!tx_valid && !done && !ok && !tmo, "R10 reset state",
          {tx_valid, done, ok, tmo}, 0);

      // immediate success
      run_start(1'b0);
      poll(1'b1, 0, 1'b0);

      // stale ticks, then polls with no ticks never expire
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
      run_start(1'b1);
      for (int i = 0; i < 5; i++) poll(1'b0, 0, 1'b0);   // R5 R7
      poll(1'b0, 2, 1'b0);
      poll(1'b0, 1, 1'b0);
      poll(1'b0, 2, 1'b0);                                 // third tick: timeout
      repeat (4) @(negedge clk);
      chk(tmo && !ok && !done, "R8 timeout held while idle", {done, ok, tmo}, 3'b001);

      // doubled tick, judge-cycle tick deferral, start while busy
      run_start(1'b0);
      poll(1'b0, 4, 1'b0);
      poll(1'b0, 3, 1'b0);
      poll(1'b0, 0, 1'b0);
      poll(1'b0, 2, 1'b1);                                 // R9 start ignored
      chk(tmo == 1'b1, "R9 busy start did not reload count", tmo, 1);

      // tick arriving in the same cycle a pending tick is consumed
      run_start(1'b0);
      poll(1'b0, 5, 1'b0);
      poll(1'b0, 0, 1'b0);
      poll(1'b0, 2, 1'b0);
      chk(tmo == 1'b1, "R6 same-cycle tick kept for next poll", tmo, 1);

      // partial count then success
      run_start(1'b0);
      poll(1'b0, 1, 1'b0);
      poll(1'b0, 0, 1'b0);
      poll(1'b1, 2, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule